// File: doc/BRIEF.md
# SCL High-Period Count Register with Bus-Idle Detector

This block keeps the standard-speed SCL high-period count of an I2C controller and hands it to the SCL timing logic. Software reaches it through a plain register port whose data path is either 8 or 32 bits wide; the field lives at byte offset 0x14. The block decides which writes land: only while the controller is switched off, never below a floor of 6, and on a byte-wide bus only as a low-then-high byte pair that commits in one step. A build parameter can freeze the field at its reset value.

The same count drives a bus-idle detector. A 16-bit run counter advances on every clock while SCL and SDA are both high and the controller is on. The idle flag rises once the run reaches the programmed count plus 10 and stays up until the run is broken.

Top module: `scl_hcnt_reg`

## Requirements
- R1: After reset the field reads 500 (0x1F4); on a 32-bit bus a read of offset 0x14 returns it zero-extended, with bits 31:16 always zero.
- R2: A write made while `ctrl_enable` is 1 leaves the field (and, on an 8-bit bus, the pending low byte) unchanged.
- R3: A committed value below 6 is stored as 6; values from 6 up are stored as written.
- R4: On a 32-bit bus a write to offset 0x14 commits `wdata[15:0]`; `wdata[31:16]` has no effect.
- R5: On an 8-bit bus a write to 0x14 loads only a pending low byte (reads of 0x14 and 0x15 still return the committed low and high bytes); a following write to 0x15 commits {high byte, pending low byte}, clamped per R3.
- R6: With `FIXED_COUNT` = 1 the field ignores all writes and keeps 500.
- R7: With both lines high and the controller on, `bus_idle` is 0 after k clocks for k < count + 10 and 1 for k ≥ count + 10.
- R8: One clock with SCL low, SDA low or `ctrl_enable` 0 restarts the run and drops `bus_idle`; once up, the flag stays up while the run continues.
- R9: `hcnt_out` always equals the committed field.
- R10: Writes to any offset other than the field's (0x14, and 0x15 on an 8-bit bus) change nothing, and reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register port select |
| wr_en | input | 1 | Write strobe (with `sel`) |
| addr | input | ADDR_W | Byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| ctrl_enable | input | 1 | Controller on; blocks writes and gates the idle run |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| hcnt_out | output | 16 | Committed high-period count |
| bus_idle | output | 1 | Bus-idle flag |

## Verification
The assertions assume that `ctrl_enable`, `scl_in` and `sda_in` are synchronous to `clk` and that a write is a single-cycle strobe sampled at the rising edge. They also assume software keeps the count at or below 65525 whenever idle detection matters, since above that the threshold exceeds the counter's range. The stimulus drives every input just after the falling edge. It keeps random writes below 0x8000 before the idle phase and programs small directed counts for the idle runs, so every threshold is reached within the run.

// File: rtl/scl_hcnt_pkg.sv
package scl_hcnt_pkg;
  localparam int CNT_W = 16;

  // Raise a requested count to the floor value.
  function automatic logic [CNT_W-1:0] floor_count(input logic [CNT_W-1:0] req,
                                                   input logic [CNT_W-1:0] lo);
    return (req < lo) ? lo : req;
  endfunction

  // Idle threshold, one bit wider so count + extra never wraps.
  function automatic logic [CNT_W:0] idle_limit(input logic [CNT_W-1:0] cnt,
                                                input logic [CNT_W-1:0] extra);
    return {1'b0, cnt} + {1'b0, extra};
  endfunction
endpackage

// File: rtl/scl_hcnt_wr_gate.sv
module scl_hcnt_wr_gate
  import scl_hcnt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ctrl_enable,
  output logic              commit,
  output logic [CNT_W-1:0]  commit_val
);
  localparam bit BYTE_BUS = (DATA_W == 8);

  logic wr_open;
  assign wr_open = sel && wr_en && !ctrl_enable;

  generate
    if (BYTE_BUS) begin : g_byte
      logic [7:0] pend_lo;
      logic       lo_hit, hi_hit;
      assign lo_hit = wr_open && (addr == ADDR_W'(BASE));
      assign hi_hit = wr_open && (addr == ADDR_W'(BASE + 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend_lo <= '0;
        else if (lo_hit) pend_lo <= wdata;
      end

      assign commit     = hi_hit;
      assign commit_val = {wdata, pend_lo};

      // R2: pending low byte frozen while controller runs
      p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_enable |=> $stable(pend_lo));
    end else begin : g_word
      logic unused_hi;
      assign unused_hi  = &{1'b0, wdata[DATA_W-1:CNT_W]};
      assign commit     = wr_open && (addr == ADDR_W'(BASE));
      assign commit_val = wdata[CNT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/scl_hcnt_store.sv
module scl_hcnt_store
  import scl_hcnt_pkg::*;
#(
  parameter int RESET_VAL = 500,
  parameter int MIN_VAL   = 6,
  parameter bit FIXED     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [CNT_W-1:0] commit_val,
  input  logic             ctrl_enable,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] RST_C = CNT_W'(RESET_VAL);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_VAL);

  generate
    if (FIXED) begin : g_fixed
      logic unused_in;
      assign unused_in = &{1'b0, commit, commit_val};
      assign count = RST_C;
      // R6: frozen field
      p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(count));
    end else begin : g_live
      logic [CNT_W-1:0] held;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held <= RST_C;
        else if (commit) held <= floor_count(commit_val, MIN_C);
      end
      assign count = held;

      // R3: never below the floor
      p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count >= MIN_C);
      // R2: gate never lets a commit through while enabled
      p_no_commit_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !ctrl_enable);
    end
  endgenerate

  // R2: field steady after any enabled cycle
  p_hold_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_enable |=> $stable(count));
endmodule

// File: rtl/scl_hcnt_idle.sv
module scl_hcnt_idle
  import scl_hcnt_pkg::*;
#(
  parameter int EXTRA = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_enable,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [CNT_W-1:0] count,
  output logic             bus_idle
);
  localparam logic [CNT_W-1:0] EXTRA_C = CNT_W'(EXTRA);

  logic [CNT_W-1:0] run_cnt;
  logic             lines_high;
  logic [CNT_W:0]   limit;

  assign lines_high = scl_in && sda_in && ctrl_enable;
  assign limit      = idle_limit(count, EXTRA_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_cnt <= '0;
    else if (!lines_high)       run_cnt <= '0;
    else if (run_cnt != '1)     run_cnt <= run_cnt + 1'b1;
  end

  assign bus_idle = ({1'b0, run_cnt} >= limit);

  // R8: any break restarts the run
  p_break_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lines_high |=> (run_cnt == '0));
  // R7: counter saturates, never wraps
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == '1) |=> (run_cnt == '1 || run_cnt == '0));
  // R8: flag only rises after a high cycle
  p_rise_needs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_idle) |-> $past(lines_high));
  // R8: flag stays while the run continues
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && lines_high) |=> bus_idle);
endmodule

// File: rtl/scl_hcnt_reg.sv
module scl_hcnt_reg
  import scl_hcnt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int BASE        = 'h14,
  parameter int RESET_VAL   = 500,
  parameter int MIN_VAL     = 6,
  parameter int IDLE_EXTRA  = 10,
  parameter bit FIXED_COUNT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ctrl_enable,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic [15:0]       hcnt_out,
  output logic              bus_idle
);
  logic             commit;
  logic [CNT_W-1:0] commit_val;
  logic [CNT_W-1:0] count;

  scl_hcnt_wr_gate #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_gate (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .ctrl_enable(ctrl_enable),
    .commit(commit), .commit_val(commit_val));

  scl_hcnt_store #(.RESET_VAL(RESET_VAL), .MIN_VAL(MIN_VAL), .FIXED(FIXED_COUNT)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_val(commit_val),
    .ctrl_enable(ctrl_enable), .count(count));

  scl_hcnt_idle #(.EXTRA(IDLE_EXTRA)) u_idle (
    .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .scl_in(scl_in),
    .sda_in(sda_in), .count(count), .bus_idle(bus_idle));

  assign hcnt_out = count;

  generate
    if (DATA_W == 8) begin : g_rd_byte
      always_comb begin
        rdata = '0;
        if (sel && addr == ADDR_W'(BASE))          rdata = count[7:0];
        else if (sel && addr == ADDR_W'(BASE + 1)) rdata = count[15:8];
      end
    end else begin : g_rd_word
      always_comb begin
        rdata = '0;
        if (sel && addr == ADDR_W'(BASE)) rdata = DATA_W'(count);
      end
      // R1: reserved upper bits read zero
      p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:CNT_W] == '0);
    end
  endgenerate
endmodule

// File: tb/scl_hcnt_reg_test.sv
module scl_hcnt_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b1;
  logic        wr8 = 1'b0, wr32 = 1'b0, wrro = 1'b0;
  logic [7:0]  addr = 8'h14;
  logic [31:0] wdata = '0;
  logic        ctrl_enable = 1'b0, scl_in = 1'b0, sda_in = 1'b0;
  logic [7:0]  rd8;
  logic [31:0] rd32, rdro;
  logic [15:0] h8, h32, hro;
  logic        idle8, idle32, idlero;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] m8 = 16'd500, m32 = 16'd500, mro = 16'd500;
  logic [7:0]  pend = 8'h00;
  bit done = 0;

  always #5 clk = ~clk;

  scl_hcnt_reg #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr8), .addr(addr), .wdata(wdata[7:0]),
    .rdata(rd8), .ctrl_enable(ctrl_enable), .scl_in(scl_in), .sda_in(sda_in),
    .hcnt_out(h8), .bus_idle(idle8));
  scl_hcnt_reg #(.DATA_W(32)) uut32 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr32), .addr(addr), .wdata(wdata),
    .rdata(rd32), .ctrl_enable(ctrl_enable), .scl_in(scl_in), .sda_in(sda_in),
    .hcnt_out(h32), .bus_idle(idle32));
  scl_hcnt_reg #(.DATA_W(32), .FIXED_COUNT(1'b1)) uut_ro (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wrro), .addr(addr), .wdata(wdata),
    .rdata(rdro), .ctrl_enable(ctrl_enable), .scl_in(scl_in), .sda_in(sda_in),
    .hcnt_out(hro), .bus_idle(idlero));

  function automatic logic [15:0] exp_floor(input logic [15:0] v);
    return (v > 16'd5) ? v : 16'd6;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input int which, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    wr8 = (which == 0); wr32 = (which == 1); wrro = (which == 2);
    @(negedge clk);
    wr8 = 0; wr32 = 0; wrro = 0;
  endtask

  // Model of byte-bus write effects.
  task automatic w8(input logic [7:0] a, input logic [7:0] d);
    pulse(0, a, {24'h0, d});
    if (!ctrl_enable) begin
      if (a == 8'h14) pend = d;
      else if (a == 8'h15) m8 = exp_floor({d, pend});
    end
  endtask

  task automatic w32(input logic [7:0] a, input logic [31:0] d);
    pulse(1, a, d);
    if (!ctrl_enable && a == 8'h14) m32 = exp_floor(d[15:0]);
  endtask

  task automatic check_all(input string tag);
    addr = 8'h14; #1;
    check({tag, " R9/R1 lo8"}, {24'h0, rd8}, {24'h0, m8[7:0]});
    check({tag, " R4/R1 rd32"}, rd32, {16'h0, m32});
    check({tag, " R6 ro"}, rdro, {16'h0, mro});
    addr = 8'h15; #1;
    check({tag, " R5 hi8"}, {24'h0, rd8}, {24'h0, m8[15:8]});
    check({tag, " R10 rd32 off"}, rd32, 32'h0);
    check({tag, " R9 hcnt8"}, {16'h0, h8}, {16'h0, m8});
    check({tag, " R9 hcnt32"}, {16'h0, h32}, {16'h0, m32});
    check({tag, " R6 hcntro"}, {16'h0, hro}, {16'h0, mro});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("reset R1");

    // R3 clamp on both buses
    w32(8'h14, 32'h0000_0002); check_all("R3 w32 small");
    w32(8'h14, 32'hABCD_0006); check_all("R3 w32 six R4");
    w8(8'h14, 8'h05); check_all("R5 lo pending");
    w8(8'h15, 8'h00); check_all("R3 R5 commit clamp");
    w8(8'h14, 8'h34); w8(8'h15, 8'h12); check_all("R5 commit 1234");
    // R4 upper write bits ignored, R1 reserved zero
    w32(8'h14, 32'hFFFF_0123); check_all("R4 upper ignored");
    // R2 writes while enabled
    ctrl_enable = 1'b1;
    w32(8'h14, 32'h0000_0777); w8(8'h14, 8'h99); w8(8'h15, 8'h01);
    check_all("R2 blocked");
    ctrl_enable = 1'b0;
    w8(8'h15, 8'h02); check_all("R2 pend kept");
    // R10 other offsets
    w32(8'h18, 32'h0000_0050); w8(8'h16, 8'h07); w32(8'h15, 32'h0000_0040);
    check_all("R10 offsets");
    // R6 read-only instance
    pulse(2, 8'h14, 32'h0000_0033); check_all("R6 ro write");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      logic [7:0] a;
      r = $urandom;
      ctrl_enable = ($urandom_range(0, 3) == 0);
      a = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(16, 31)) : 8'h14;
      if (r[4]) r[15:0] = 16'($urandom_range(0, 9));
      r[15] = 1'b0;
      case ($urandom_range(0, 3))
        0: w32(a, r);
        1: w8(a, r[7:0]);
        2: w8(8'h15, r[15:8]);
        default: pulse(2, a, r);
      endcase
      check_all("rand R2 R3 R4 R5");
    end

    // Idle detector: R7 R8
    ctrl_enable = 1'b0;
    w8(8'h14, 8'h03); w8(8'h15, 8'h00);        // clamps to 6
    w32(8'h14, 32'h0000_0028);                 // 40
    check_all("idle setup");
    @(negedge clk);
    ctrl_enable = 1'b1; scl_in = 1'b1; sda_in = 1'b1;
    #1;
    check("R7 idle8 k0", {31'h0, idle8}, 32'h0);
    for (int k = 1; k <= 515; k++) begin
      @(negedge clk); #1;
      check("R7 idle8", {31'h0, idle8}, {31'h0, (k >= 32'(m8) + 10)});
      check("R7 idle32", {31'h0, idle32}, {31'h0, (k >= 32'(m32) + 10)});
      check("R7 idlero", {31'h0, idlero}, {31'h0, (k >= 32'(mro) + 10)});
    end
    sda_in = 1'b0;
    @(negedge clk); #1;
    check("R8 sda low", {31'h0, idle8 | idle32 | idlero}, 32'h0);
    sda_in = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk); #1;
      check("R8 rerun", {31'h0, idle8}, {31'h0, (k >= 16)});
    end
    scl_in = 1'b0;
    @(negedge clk); #1;
    check("R8 scl low", {31'h0, idle8}, 32'h0);
    scl_in = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    check("R8 back idle", {31'h0, idle8}, 32'h1);
    ctrl_enable = 1'b0;
    @(negedge clk); #1;
    check("R8 disabled", {31'h0, idle8}, 32'h0);
    @(negedge clk); #1;
    check("R8 stays off", {31'h0, idle8}, 32'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule